// File: doc/BRIEF.md
# Beacon Transmit Timing Generator

This block produces the three periodic beacon events that a node sending beacons needs: the target beacon transmission time (TBTT), an earlier alert for the beacon DMA engine, and an earlier alert for software. It contains a free-running microsecond time-stamp counter (TSF) that advances by one on each `us_tick` strobe. It also holds one target register per event. When the counter reaches or passes a target, the block emits a one-cycle pulse and moves that target forward by the beacon period.

Software configures the block through a simple write port. A single "next beacon" write, given in units of 1/8 TU, loads all three targets at once. The TBTT target is that time converted to microseconds. Each alert target is the same time minus its own programmed lead time. A period write sets one common period for all three timers, and can also clear the time-stamp counter. Each timer has its own enable bit. A separate mode write sets a sticky transmit-policy flag for ad hoc operation.

Top module: `bcn_timing_gen`

## Requirements
- R1: While reset is asserted, `evt_o` is 0, `tsf_o` is 0 and `adhoc_policy_o` is 0. After reset, all enables, periods, lead times and targets are 0.
- R2: `tsf_o` increases by one in the cycle after each cycle in which `us_tick` is high. A write to address 3 with `wr_data[31]` set makes `tsf_o` read 0 in the cycle after the write, and this clear takes priority over the tick.
- R3: A write to address 0 sets the TBTT target to `wr_data[24:0]` shifted left by 7, which converts 1/8 TU to microseconds.
- R4: The same address-0 write sets the DMA alert target to the TBTT target minus the DMA lead. The DMA lead is written at address 1 in `wr_data[15:0]`, in microseconds. The write also sets the software alert target to the TBTT target minus the software lead, which is written at address 2. Both leads are the values held before the address-0 write.
- R5: A write to address 3 sets the period of all three timers to `wr_data[15:0]` shifted left by 7, in microseconds.
- R6: `evt_o` bit 0 is the TBTT event, bit 1 the DMA alert and bit 2 the software alert. A bit pulses for one cycle in the cycle after `tsf_o` first shows a value greater than or equal to that timer's target, provided the timer is enabled.
- R7: Each time a target is due, it gains one period per cycle until it lies beyond the counter. When the target is several periods in the past, only one pulse is emitted for the whole catch-up.
- R8: The enables are written at address 4: bit 0 for TBTT, bit 1 for DMA and bit 2 for software. A disabled timer emits no pulse. A target that comes due while its timer is disabled is still advanced, so re-enabling the timer produces no late pulse.
- R9: An address-0 write replaces any pending target and cancels any catch-up in progress, even when the old target comes due in the same cycle. Only the new target fires from then on.
- R10: Writing address 5 with bit 0 set selects ad hoc mode and sets `adhoc_policy_o`, which then stays set until reset. Writing bit 0 clear (access point mode) leaves the flag unchanged.
- R11: With a period of 0, a timer fires once when its target is reached and then stays silent until its target is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| us_tick | input | 1 | One-microsecond strobe that advances the time-stamp counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 next beacon, 1 DMA lead, 2 software lead, 3 period, 4 enables, 5 mode) |
| wr_data | input | 32 | Register write data |
| tsf_o | output | 32 | Current time-stamp counter value in microseconds |
| evt_o | output | 3 | One-cycle event pulses: bit 0 TBTT, bit 1 DMA alert, bit 2 software alert |
| adhoc_policy_o | output | 1 | Sticky ad hoc beacon transmit-policy flag |

## Verification
Two functions can fall in the same cycle. In the first, a timer comes due and emits its pulse in the same cycle that software writes a new next-beacon value. In the second, the counter is cleared in the same cycle that a target is being reached or advanced. Both are provoked by random writes of past and near-future targets and random period writes that carry the clear flag, issued while the counter is close to live targets. A cycle-level reference model in the bench, built from the requirements, judges the event vector and the counter on every cycle. Directed cases additionally pin down pulse times, catch-up over several periods, late re-enable and a zero period.

// File: rtl/bcn_pkg.sv
package bcn_pkg;
  localparam int ADDR_W = 3;
  localparam int N_TMR  = 3;

  // timer slots; bit order of the event vector
  localparam int TMR_TBTT = 0;
  localparam int TMR_DMA  = 1;
  localparam int TMR_SW   = 2;

  // register addresses
  localparam logic [ADDR_W-1:0] A_NEXT     = 3'd0;
  localparam logic [ADDR_W-1:0] A_DMA_LEAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_SW_LEAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PERIOD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd4;
  localparam logic [ADDR_W-1:0] A_MODE     = 3'd5;
endpackage

// File: rtl/bcn_tsf_ctr.sv
module bcn_tsf_ctr #(
  parameter int TSF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [TSF_W-1:0] tsf_q
);
  logic [TSF_W-1:0] tsf_d;
  logic             tsf_ce;

  // R2: clear wins over tick
  always_comb begin
    tsf_ce = clr | tick;
    tsf_d  = tsf_q;
    if (clr)       tsf_d = '0;
    else if (tick) tsf_d = tsf_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tsf_q <= '0;
    else if (tsf_ce) tsf_q <= tsf_d;
  end
endmodule

// File: rtl/bcn_cfg_regs.sv
module bcn_cfg_regs
  import bcn_pkg::*;
#(
  parameter int TSF_W   = 32,
  parameter int DATA_W  = 32,
  parameter int PER_W   = 16,
  parameter int LEAD_W  = 16,
  parameter int UNIT_SH = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic                         load,
  output logic [N_TMR-1:0][TSF_W-1:0]  load_val,
  output logic [TSF_W-1:0]             period_q,
  output logic [N_TMR-1:0]             en_q,
  output logic                         policy_q,
  output logic                         tsf_clr
);
  localparam int NB_W = TSF_W - UNIT_SH;

  logic              hit_dma, hit_sw, hit_per, hit_en, hit_mode;
  logic [TSF_W-1:0]  base_us;
  logic [LEAD_W-1:0] dma_lead_q, sw_lead_q;
  logic [TSF_W-1:0]  period_d;
  logic              policy_d;
  logic              unused_bits;

  assign unused_bits = ^wr_data[DATA_W-2:NB_W];

  always_comb begin
    load     = wr_en && (wr_addr == A_NEXT);
    hit_dma  = wr_en && (wr_addr == A_DMA_LEAD);
    hit_sw   = wr_en && (wr_addr == A_SW_LEAD);
    hit_per  = wr_en && (wr_addr == A_PERIOD);
    hit_en   = wr_en && (wr_addr == A_ENABLE);
    hit_mode = wr_en && (wr_addr == A_MODE);
    // R3: 1/8 TU to microseconds
    base_us  = {wr_data[NB_W-1:0], {UNIT_SH{1'b0}}};
    // R4: alerts lead the beacon by their own lead times
    load_val[TMR_TBTT] = base_us;
    load_val[TMR_DMA]  = base_us - TSF_W'(dma_lead_q);
    load_val[TMR_SW]   = base_us - TSF_W'(sw_lead_q);
    // R5: one period for all three timers
    period_d = TSF_W'(wr_data[PER_W-1:0]) << UNIT_SH;
    tsf_clr  = hit_per && wr_data[DATA_W-1];
    // R10: sticky once ad hoc is chosen
    policy_d = policy_q | wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_lead_q <= '0;
      sw_lead_q  <= '0;
      period_q   <= '0;
      en_q       <= '0;
      policy_q   <= 1'b0;
    end else begin
      if (hit_dma)  dma_lead_q <= wr_data[LEAD_W-1:0];
      if (hit_sw)   sw_lead_q  <= wr_data[LEAD_W-1:0];
      if (hit_per)  period_q   <= period_d;
      if (hit_en)   en_q       <= wr_data[N_TMR-1:0];
      if (hit_mode) policy_q   <= policy_d;
    end
  end
endmodule

// File: rtl/bcn_evt_timer.sv
module bcn_evt_timer #(
  parameter int TSF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TSF_W-1:0] tsf,
  input  logic             enable,
  input  logic [TSF_W-1:0] period,
  input  logic             load,
  input  logic [TSF_W-1:0] load_val,
  output logic             evt_q,
  output logic [TSF_W-1:0] next_q
);
  logic             due, fire, catch_q, catch_d, next_ce;
  logic [TSF_W-1:0] next_d;

  always_comb begin
    due     = tsf >= next_q;
    // R6/R7/R8: one pulse per due episode, only when enabled
    fire    = enable && due && !catch_q;
    next_ce = load || due;
    if (load) begin
      // R9: a fresh target replaces everything pending
      next_d  = load_val;
      catch_d = 1'b0;
    end else begin
      next_d  = next_q + period;
      catch_d = due;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      catch_q <= 1'b0;
      next_q  <= '0;
    end else begin
      evt_q   <= fire;
      catch_q <= catch_d;
      if (next_ce) next_q <= next_d;
    end
  end
endmodule

// File: rtl/bcn_timing_gen.sv
module bcn_timing_gen
  import bcn_pkg::*;
#(
  parameter int TSF_W   = 32,
  parameter int DATA_W  = 32,
  parameter int PER_W   = 16,
  parameter int LEAD_W  = 16,
  parameter int UNIT_SH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TSF_W-1:0]  tsf_o,
  output logic [N_TMR-1:0]  evt_o,
  output logic              adhoc_policy_o
);
  logic [1:0]                  rst_pipe;
  logic                        rst_sync_n;
  logic                        load, tsf_clr;
  logic [N_TMR-1:0][TSF_W-1:0] load_val;
  logic [N_TMR-1:0][TSF_W-1:0] next_at;
  logic [TSF_W-1:0]            period_q;
  logic [N_TMR-1:0]            tmr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  bcn_cfg_regs #(
    .TSF_W(TSF_W), .DATA_W(DATA_W), .PER_W(PER_W),
    .LEAD_W(LEAD_W), .UNIT_SH(UNIT_SH)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .load_val(load_val), .period_q(period_q),
    .en_q(tmr_en), .policy_q(adhoc_policy_o), .tsf_clr(tsf_clr)
  );

  bcn_tsf_ctr #(.TSF_W(TSF_W)) u_tsf (
    .clk(clk), .rst_n(rst_sync_n), .tick(us_tick),
    .clr(tsf_clr), .tsf_q(tsf_o)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    bcn_evt_timer #(.TSF_W(TSF_W)) u_tmr (
      .clk(clk), .rst_n(rst_sync_n), .tsf(tsf_o),
      .enable(tmr_en[i]), .period(period_q),
      .load(load), .load_val(load_val[i]),
      .evt_q(evt_o[i]), .next_q(next_at[i])
    );
  end
endmodule

// File: rtl/bcn_timing_chk.sv
module bcn_timing_chk #(
  parameter int TSF_W = 32,
  parameter int N     = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr_req,
  input logic                    us_tick,
  input logic [TSF_W-1:0]        tsf,
  input logic [N-1:0]            evt,
  input logic [N-1:0]            en,
  input logic [N-1:0][TSF_W-1:0] next_at,
  input logic                    policy
);
  p_tsf_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (tsf == '0));

  p_tsf_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> (tsf == $past(tsf) + TSF_W'($past(us_tick))));

  p_policy_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    policy |=> policy);

  for (genvar i = 0; i < N; i++) begin : g_evt
    p_evt_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |-> $past(en[i]));
    p_evt_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |-> $past(tsf >= next_at[i]));
  end
endmodule

bind bcn_timing_gen bcn_timing_chk #(.TSF_W(TSF_W), .N(3)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .clr_req(wr_en && (wr_addr == 3'd3) && wr_data[DATA_W-1]),
  .us_tick(us_tick), .tsf(tsf_o), .evt(evt_o), .en(tmr_en),
  .next_at(next_at), .policy(adhoc_policy_o)
);

// File: tb/bcn_timing_gen_test.sv
module bcn_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] tsf_o;
  logic [2:0]  evt_o;
  logic        adhoc_policy_o;

  bcn_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tsf_o(tsf_o),
    .evt_o(evt_o), .adhoc_policy_o(adhoc_policy_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  int unsigned cnt [3];
  logic [31:0] first_tsf [3];
  logic [31:0] second_tsf [3];
  logic [31:0] last_tsf [3];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, built from the requirements
  logic [31:0] m_tsf, m_per, m_dl, m_sl;
  logic [31:0] m_next [3];
  bit   [2:0]  m_en, m_cat, m_evt;
  bit          m_pol;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] base;
    logic [31:0] tv [3];
    bit ld, ge;
    if (!rst_n) begin
      m_tsf = 0; m_per = 0; m_dl = 0; m_sl = 0;
      m_en = 0; m_cat = 0; m_evt = 0; m_pol = 0;
      for (int i = 0; i < 3; i++) m_next[i] = 0;
    end else begin
      ld = wr_en && wr_addr == 3'd0;
      base = {wr_data[24:0], 7'b0};
      tv[0] = base; tv[1] = base - m_dl; tv[2] = base - m_sl;
      for (int i = 0; i < 3; i++) begin
        ge = m_tsf >= m_next[i];
        m_evt[i] = m_en[i] && ge && !m_cat[i];
        if (ld) begin
          m_next[i] = tv[i]; m_cat[i] = 0;
        end else begin
          if (ge) m_next[i] = m_next[i] + m_per;
          m_cat[i] = ge;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd1: m_dl = {16'b0, wr_data[15:0]};
          3'd2: m_sl = {16'b0, wr_data[15:0]};
          3'd3: m_per = {9'b0, wr_data[15:0], 7'b0};
          3'd4: m_en = wr_data[2:0];
          3'd5: if (wr_data[0]) m_pol = 1;
          default: ;
        endcase
      end
      if (wr_en && wr_addr == 3'd3 && wr_data[31]) m_tsf = 0;
      else m_tsf = m_tsf + {31'b0, us_tick};
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (evt_o[i]) begin
        if (cnt[i] == 0) first_tsf[i] = tsf_o;
        else if (cnt[i] == 1) second_tsf[i] = tsf_o;
        last_tsf[i] = tsf_o;
        cnt[i]++;
      end
    end
    if (cmp_on) begin
      chk(evt_o == m_evt, "R6 event vector vs model", evt_o, m_evt);
      chk(tsf_o == m_tsf, "R2 counter vs model", tsf_o, m_tsf);
      chk(adhoc_policy_o == m_pol, "R10 policy vs model", adhoc_policy_o, m_pol);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_tsf(input logic [31:0] v);
    for (int g = 0; g < 20000 && tsf_o < v; g++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned c0, c1;
    logic [31:0] t, nt;
    for (int i = 0; i < 3; i++) cnt[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) step();
    chk(evt_o == 3'b000, "R1 events in reset", evt_o, 0);
    chk(tsf_o == 0, "R1 counter in reset", tsf_o, 0);
    chk(adhoc_policy_o == 1'b0, "R1 policy in reset", adhoc_policy_o, 0);
    rst_n = 1'b1;
    repeat (4) step();
    cmp_on = 1'b1;

    // R10: access point mode leaves flag, ad hoc sets it for good
    wr(3'd5, 32'd0);
    chk(adhoc_policy_o == 1'b0, "R10 AP mode keeps flag clear", adhoc_policy_o, 0);
    wr(3'd5, 32'd1);
    chk(adhoc_policy_o == 1'b1, "R10 ad hoc sets flag", adhoc_policy_o, 1);
    wr(3'd5, 32'd0);
    chk(adhoc_policy_o == 1'b1, "R10 flag sticky", adhoc_policy_o, 1);

    us_tick = 1'b1;
    wr(3'd1, 32'd100);
    wr(3'd2, 32'd300);
    wr(3'd3, 32'h8000_0008);
    chk(tsf_o == 0, "R2 clear on period write", tsf_o, 0);
    wr(3'd0, 32'd4);
    wr(3'd4, 32'd7);
    for (int g = 0; g < 4000 && cnt[0] < 2; g++) step();
    chk(first_tsf[0] - 1 == 512, "R3 TBTT time", first_tsf[0] - 1, 512);
    chk(first_tsf[1] - 1 == 412, "R4 DMA alert time", first_tsf[1] - 1, 412);
    chk(first_tsf[2] - 1 == 212, "R4 SW alert time", first_tsf[2] - 1, 212);
    chk(second_tsf[0] - 1 == 1536, "R5 TBTT one period later", second_tsf[0] - 1, 1536);

    // R8: DMA alert due at 2460 while disabled, then re-enabled
    wr(3'd4, 32'd5);
    c1 = cnt[1]; c0 = cnt[0];
    wait_tsf(32'd2470);
    wr(3'd4, 32'd7);
    wait_tsf(32'd2600);
    chk(cnt[1] == c1, "R8 disabled alert dropped", cnt[1], c1);
    chk(cnt[0] == c0 + 1, "R8 enabled TBTT still fires", cnt[0], c0 + 1);

    // R7: target several periods in the past
    c0 = cnt[0];
    wr(3'd0, 32'd1);
    repeat (8) step();
    chk(cnt[0] == c0 + 1, "R7 one pulse over catch-up", cnt[0], c0 + 1);
    for (int g = 0; g < 3000 && cnt[0] < c0 + 2; g++) step();
    chk((last_tsf[0] - 1 - 128) % 1024 == 0, "R7 re-armed on period grid",
        (last_tsf[0] - 1 - 128) % 1024, 0);

    // R9: override a pending target with a later one
    t = tsf_o;
    nt = ((t >> 7) + 20) << 7;
    c0 = cnt[0];
    wr(3'd0, nt >> 7);
    wait_tsf(nt + 2);
    chk(cnt[0] == c0 + 1, "R9 only new target fires", cnt[0], c0 + 1);
    chk(last_tsf[0] - 1 == nt, "R9 new target time", last_tsf[0] - 1, nt);

    // R11: zero period fires once
    wr(3'd3, 32'd0);
    t = tsf_o;
    nt = ((t >> 7) + 4) << 7;
    c0 = cnt[0];
    wr(3'd0, nt >> 7);
    wait_tsf(nt + 3000);
    chk(cnt[0] == c0 + 1, "R11 single pulse with zero period", cnt[0], c0 + 1);

    // random mix, judged by the model
    for (int k = 0; k < 20000; k++) begin
      int f;
      logic [2:0] a;
      step();
      wr_en = 1'b0;
      us_tick = ($urandom % 4) != 0;
      if ($urandom % 48 == 0) begin
        a = 3'($urandom % 6);
        wr_en = 1'b1; wr_addr = a;
        case (a)
          3'd0: begin
            f = int'(tsf_o >> 7) + int'($urandom % 24) - 4;
            if (f < 0) f = 0;
            wr_data = 32'(f);
          end
          3'd1, 3'd2: wr_data = $urandom % 400;
          3'd3: wr_data = ($urandom % 12) | (($urandom % 16 == 0) ? 32'h8000_0000 : 32'h0);
          3'd4: wr_data = $urandom % 8;
          default: wr_data = $urandom % 2;
        endcase
      end
    end
    step();
    wr_en = 1'b0;
    step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule